// File: doc/BRIEF.md
# Memory Card Socket Status and Control Unit

This unit connects a small word-addressed register bus to the sideband pins of a removable memory card socket. It brings the card-detect, READY and write-protect pins into the clock domain and records a sticky event whenever one of them changes. Any recorded event that is not masked drives a single interrupt line. Software finds out what happened by reading a status word, and that read also clears the recorded events.

The unit also drives the card reset pin and the select between attribute and common memory space. System accesses that fall inside a programmable base/size window are passed to the card with the base subtracted, so the card sees addresses starting at zero. Read data coming back from the card has its odd byte forced to zero while attribute space is selected. Registers are at word offsets: 0 status (read only), 1 event mask, 2 control, 3 window base, 4 window size.

Top module: `mcard_ctl`

## Requirements
- R1: Card-detect, READY and write-protect each pass through a two-flop synchronizer. A change between successive synchronized samples sets a sticky event bit in status: bit 0 for detect, bit 1 for READY, bit 2 for write-protect.
- R2: The `irq` output is high exactly when some pending event has its mask bit clear. Mask register bits 0..2 use the same positions as the events, and a mask bit of 1 excludes that event. The mask resets to 0.
- R3: A read of status (offset 0) returns the pending events and then clears them. The data appears on `bus_rdata` one cycle after the request, with `bus_rvalid` high.
- R4: If an event is detected in the same cycle as a status read, that event stays pending after the read.
- R5: Status bits 4, 5 and 6 show the current synchronized levels of detect, READY and write-protect. All other status bits read 0.
- R6: `card_rst` is high after reset. Control bit 0 is the software reset and resets to 1. While it is 1, `card_rst` stays high. `card_rst` goes low only after software writes the bit to 0 and a card is present.
- R7: Whenever the synchronized detect level is 0, `card_rst` is high, whatever the software reset bit holds.
- R8: Control bit 1 drives `card_attr`: 1 selects attribute space and 0 selects common space. The bit resets to 0.
- R9: A valid system access at an address A with base <= A < base+size asserts `card_cs` one cycle later, with `card_addr` = A - base.
- R10: An access below the base, at or above base+size, or any access while size is 0, leaves `card_cs` low. With no valid access, `card_cs` is low.
- R11: `sys_rdata` is the card data registered one cycle later. When attribute space is selected, bits 15:8 read 0 and only the even byte is passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | REG_AW | Register word offset |
| bus_wdata | input | SYS_AW | Write data |
| bus_rdata | output | SYS_AW | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Unmasked event pending |
| card_det | input | 1 | Card present pin (1 = present) |
| card_ready | input | 1 | Card READY pin |
| card_wp | input | 1 | Card write-protect pin |
| card_rst | output | 1 | Card reset |
| card_attr | output | 1 | Attribute space select |
| sys_valid | input | 1 | System access to the card window |
| sys_addr | input | SYS_AW | System address |
| card_cs | output | 1 | Card chip-select |
| card_addr | output | CARD_AW | Card-relative address |
| card_din | input | DATA_W | Data from the card |
| sys_rdata | output | DATA_W | Card data returned to the system |

## Verification
The sharpest corner is an event that is detected in the very cycle a status read clears the register. A design that lets the clear win loses that event for good. The bench times a READY edge to land on the read and expects the event on the next read. It also removes the card while the software reset is released: a design that only obeys the software bit would leave the card running with no card present. Addresses one below the window, on the last word of the window and one past it, plus a zero-size window, catch off-by-one comparisons. Masked events must stay latched without raising `irq`, and attribute reads must return a zero odd byte.

// File: rtl/mcard_pkg.sv
package mcard_pkg;
  localparam int NEVT = 3;

  // event / level bit positions inside the status word
  localparam int EV_DET = 0;
  localparam int EV_RDY = 1;
  localparam int EV_WP  = 2;
  localparam int LVL_LSB = 4;

  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_MASK = 3'd1,
    REG_CTRL = 3'd2,
    REG_BASE = 3'd3,
    REG_SIZE = 3'd4
  } reg_ofs_e;

  localparam int CTRL_SRST = 0;
  localparam int CTRL_ATTR = 1;
endpackage

// File: rtl/mcard_sync.sv
module mcard_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], pin[i]};
    end
    assign lvl[i] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= lvl;
  end

  assign chg = lvl ^ prev_q;
endmodule

// File: rtl/mcard_evt.sv
module mcard_evt #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] chg,
  input  logic         clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_d;

  // a fresh change always survives a clear in the same cycle
  always_comb begin
    pend_d = (clr ? '0 : pend) | chg;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      irq  <= |(pend_d & ~mask);
    end
  end
endmodule

// File: rtl/mcard_win.sv
module mcard_win #(
  parameter int SYS_AW  = 32,
  parameter int CARD_AW = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               valid,
  input  logic [SYS_AW-1:0]  addr,
  input  logic [SYS_AW-1:0]  base,
  input  logic [SYS_AW-1:0]  size,
  output logic               cs,
  output logic [CARD_AW-1:0] caddr
);
  logic [SYS_AW-1:0] off;
  logic              hit;

  always_comb begin
    off = addr - base;
    hit = (addr >= base) && (off < size);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs    <= 1'b0;
      caddr <= '0;
    end else begin
      cs    <= valid && hit;
      caddr <= off[CARD_AW-1:0];
    end
  end
endmodule

// File: rtl/mcard_ctl.sv
module mcard_ctl
  import mcard_pkg::*;
#(
  parameter int SYS_AW  = 32,
  parameter int CARD_AW = 16,
  parameter int DATA_W  = 16,
  parameter int REG_AW  = 3,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [REG_AW-1:0]  bus_addr,
  input  logic [SYS_AW-1:0]  bus_wdata,
  output logic [SYS_AW-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic               irq,
  input  logic               card_det,
  input  logic               card_ready,
  input  logic               card_wp,
  output logic               card_rst,
  output logic               card_attr,
  input  logic               sys_valid,
  input  logic [SYS_AW-1:0]  sys_addr,
  output logic               card_cs,
  output logic [CARD_AW-1:0] card_addr,
  input  logic [DATA_W-1:0]  card_din,
  output logic [DATA_W-1:0]  sys_rdata
);
  localparam int HALF_W = DATA_W / 2;

  logic [NEVT-1:0]   lvl, chg, pend, mask_q;
  logic              srst_q, attr_q, card_rst_q;
  logic [SYS_AW-1:0] base_q, size_q, stat_word, rd_mux;
  logic              wr_en, rd_en, stat_rd;
  logic              unused_wbits;

  assign wr_en   = bus_valid && bus_write;
  assign rd_en   = bus_valid && !bus_write;
  assign stat_rd = rd_en && (bus_addr == REG_AW'(REG_STAT));
  assign unused_wbits = ^bus_wdata[SYS_AW-1:NEVT];

  mcard_sync #(.N(NEVT), .STAGES(SYNC_N)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin ({card_wp, card_ready, card_det}),
    .lvl (lvl),
    .chg (chg)
  );

  mcard_evt #(.N(NEVT)) u_evt (
    .clk  (clk),
    .rst  (rst),
    .chg  (chg),
    .clr  (stat_rd),
    .mask (mask_q),
    .pend (pend),
    .irq  (irq)
  );

  mcard_win #(.SYS_AW(SYS_AW), .CARD_AW(CARD_AW)) u_win (
    .clk   (clk),
    .rst   (rst),
    .valid (sys_valid),
    .addr  (sys_addr),
    .base  (base_q),
    .size  (size_q),
    .cs    (card_cs),
    .caddr (card_addr)
  );

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      srst_q <= 1'b1;
      attr_q <= 1'b0;
      base_q <= '0;
      size_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        REG_AW'(REG_MASK): mask_q <= bus_wdata[NEVT-1:0];
        REG_AW'(REG_CTRL): begin
          srst_q <= bus_wdata[CTRL_SRST];
          attr_q <= bus_wdata[CTRL_ATTR];
        end
        REG_AW'(REG_BASE): base_q <= bus_wdata;
        REG_AW'(REG_SIZE): size_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  // status word: pending events low, synchronized levels above
  always_comb begin
    stat_word = '0;
    stat_word[NEVT-1:0] = pend;
    stat_word[LVL_LSB +: NEVT] = lvl;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_AW'(REG_STAT): rd_mux = stat_word;
      REG_AW'(REG_MASK): rd_mux[NEVT-1:0] = mask_q;
      REG_AW'(REG_CTRL): begin
        rd_mux[CTRL_SRST] = srst_q;
        rd_mux[CTRL_ATTR] = attr_q;
      end
      REG_AW'(REG_BASE): rd_mux = base_q;
      REG_AW'(REG_SIZE): rd_mux = size_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
    end
  end

  // card reset: held by software bit or by missing card
  always_ff @(posedge clk) begin
    if (rst) card_rst_q <= 1'b1;
    else     card_rst_q <= srst_q || !lvl[EV_DET];
  end
  assign card_rst  = card_rst_q;
  assign card_attr = attr_q;

  // return path: attribute space only carries the even byte
  always_ff @(posedge clk) begin
    if (rst) sys_rdata <= '0;
    else if (attr_q) sys_rdata <= {{HALF_W{1'b0}}, card_din[HALF_W-1:0]};
    else             sys_rdata <= card_din;
  end
endmodule

// File: rtl/mcard_ctl_chk.sv
module mcard_ctl_chk #(
  parameter int N = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              stat_rd,
  input logic [N-1:0]      chg,
  input logic [N-1:0]      pend,
  input logic [N-1:0]      mask_q,
  input logic              irq,
  input logic              card_det,
  input logic              card_rst,
  input logic              card_attr,
  input logic              sys_valid,
  input logic              card_cs,
  input logic [DATA_W-1:0] sys_rdata
);
  // R3
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && chg == '0) |=> (pend == '0));

  // R4
  keep_new_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (chg != '0) |=> ((pend & $past(chg)) == $past(chg)));

  // R2
  all_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '1) |=> !irq);

  // R7
  no_card_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(card_det, 3) && !$past(card_det, 2)) |-> card_rst);

  // R6
  rst_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> card_rst);

  // R10
  idle_no_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !sys_valid |=> !card_cs);

  // R11
  attr_odd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    card_attr |=> (sys_rdata[DATA_W-1:DATA_W/2] == '0));
endmodule

bind mcard_ctl mcard_ctl_chk #(.N(mcard_pkg::NEVT), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stat_rd   (stat_rd),
  .chg       (chg),
  .pend      (pend),
  .mask_q    (mask_q),
  .irq       (irq),
  .card_det  (card_det),
  .card_rst  (card_rst),
  .card_attr (card_attr),
  .sys_valid (sys_valid),
  .card_cs   (card_cs),
  .sys_rdata (sys_rdata)
);

// File: tb/mcard_ctl_tb.sv
module mcard_ctl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq;
  logic        card_det = 1'b0, card_ready = 1'b0, card_wp = 1'b0;
  logic        card_rst, card_attr;
  logic        sys_valid = 1'b0;
  logic [31:0] sys_addr = '0;
  logic        card_cs;
  logic [15:0] card_addr, card_din = '0, sys_rdata;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [31:0] rd;

  always #2 clk = ~clk;

  mcard_ctl u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq), .card_det(card_det),
    .card_ready(card_ready), .card_wp(card_wp), .card_rst(card_rst),
    .card_attr(card_attr), .sys_valid(sys_valid), .sys_addr(sys_addr),
    .card_cs(card_cs), .card_addr(card_addr), .card_din(card_din),
    .sys_rdata(sys_rdata)
  );

  // window vectors: {address, expected cs, expected card address}
  localparam logic [48:0] WIN_VEC [6] = '{
    {32'h0000_1000, 1'b1, 16'h0000},
    {32'h0000_1042, 1'b1, 16'h0042},
    {32'h0000_10FF, 1'b1, 16'h00FF},
    {32'h0000_1100, 1'b0, 16'h0000},
    {32'h0000_0FFF, 1'b0, 16'h0000},
    {32'h8000_1000, 1'b0, 16'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rdreg(input logic [2:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL R3 rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic access(input logic [31:0] a, output logic cs, output logic [15:0] ca);
    sys_valid = 1'b1; sys_addr = a;
    @(negedge clk);
    sys_valid = 1'b0;
    cs = card_cs; ca = card_addr;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic cs;
    logic [15:0] ca;
    waitn(4);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R6 card_rst after reset", card_rst, 1);
    chk("R8 card_attr after reset", card_attr, 0);
    chk("R2 irq after reset", irq, 0);
    chk("R10 card_cs after reset", card_cs, 0);
    rdreg(3'd0, rd); chk("R3 status after reset", rd, 32'h0);

    // window table: R9 hits, R10 misses
    wr(3'd3, 32'h0000_1000);
    wr(3'd4, 32'h0000_0100);
    for (int i = 0; i < 6; i++) begin
      access(WIN_VEC[i][48:17], cs, ca);
      chk(WIN_VEC[i][16] ? "R9 window hit cs" : "R10 window miss cs", cs, WIN_VEC[i][16]);
      if (WIN_VEC[i][16]) chk("R9 card address", ca, WIN_VEC[i][15:0]);
    end

    // insertion: R1 event, R5 level, R3 clear
    card_det = 1'b1; waitn(4);
    chk("R2 irq on unmasked insert", irq, 1);
    rdreg(3'd0, rd); chk("R1 R5 insert status", rd, 32'h11);
    chk("R3 irq low after read", irq, 0);
    rdreg(3'd0, rd); chk("R3 events cleared", rd, 32'h10);
    chk("R6 soft bit holds reset", card_rst, 1);

    wr(3'd2, 32'h0); waitn(2);
    chk("R6 reset released", card_rst, 0);

    // R4: READY edge lands on the status read
    card_ready = 1'b1;
    waitn(2);
    rdreg(3'd0, rd); chk("R4 read during event", rd, 32'h30);
    rdreg(3'd0, rd); chk("R4 event kept after clear", rd, 32'h32);

    // R2: masked write-protect event stays pending but silent
    wr(3'd1, 32'h4);
    card_wp = 1'b1; waitn(4);
    chk("R2 masked event no irq", irq, 0);
    rdreg(3'd0, rd); chk("R2 masked event latched", rd, 32'h74);
    wr(3'd1, 32'h0);
    card_wp = 1'b0; waitn(4);
    chk("R2 unmasked irq", irq, 1);
    rdreg(3'd0, rd); chk("R1 wp event", rd, 32'h34);

    // R8 / R11: attribute space, odd byte zeroed
    wr(3'd2, 32'h2);
    chk("R8 attr selected", card_attr, 1);
    card_din = 16'hABCD; @(negedge clk);
    chk("R11 attr even byte only", sys_rdata, 16'h00CD);
    wr(3'd2, 32'h0);
    chk("R8 common selected", card_attr, 0);
    @(negedge clk);
    chk("R11 common full word", sys_rdata, 16'hABCD);

    // R6 software reset reassert/release
    wr(3'd2, 32'h1); waitn(2);
    chk("R6 soft reset asserts", card_rst, 1);
    wr(3'd2, 32'h0); waitn(2);
    chk("R6 soft reset released", card_rst, 0);

    // R7: removal forces reset
    card_det = 1'b0; waitn(4);
    chk("R7 removal forces reset", card_rst, 1);
    rdreg(3'd0, rd); chk("R1 removal event", rd, 32'h21);

    // R10: zero-size window
    wr(3'd4, 32'h0);
    access(32'h0000_1000, cs, ca);
    chk("R10 zero size no cs", cs, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule